// File: doc/BRIEF.md
# Interrupt Deactivation Write Handler

This block is the deactivate path of an interrupt controller's processor-side interface. Software writes a 32-bit word to one write-only register to end the active life of an interrupt after its priority was dropped on its own. The block checks whether the write may act. That depends on the split priority-drop/deactivate mode bits and the security state of the access. If the write may act, the block clears the named interrupt's bit in a local active-state bitmap.

Writes that are refused can raise a one-cycle error pulse. Software-generated interrupts keep one active bit per source processor. The identifier field is decoded in two layouts, selected by whether affinity routing is enabled.

Two strobed inputs model the rest of the controller. One marks an interrupt active and sets its bit in an active-priority bitmap. The other is the priority drop, which clears a bit in that same bitmap. A deactivate write never touches the active-priority bitmap.

Top module: `intr_deact_unit`

## Requirements
- R1: A write to offset 0x1000 whose governing split mode is 1 and whose target slot is active clears that slot's bit in `active_map_o` one cycle later.
- R2: With `sec_dis_i`=1 the only governing mode bit is `split_mode_i`, and `wr_secure_i` plays no part.
- R3: With `sec_dis_i`=0 a write with `wr_secure_i`=1 is governed by `split_mode_s_i`, and a write with `wr_secure_i`=0 is governed by `split_mode_ns_i`.
- R4: A write whose governing mode bit is 0 leaves all state unchanged, whatever identifier it names, and pulses `err_o` if `err_en_i`=1.
- R5: A write naming an identifier at or above NUM_IRQ, or a slot that is not active, leaves all state unchanged and pulses `err_o` if `err_en_i`=1.
- R6: With the governing mode bit at 1, a write naming identifier 1020, 1021, 1022 or 1023 changes no state and raises no error.
- R7: With `aff_route_i`=0 the identifier is data bits 9:0, and bits 31:13 are ignored. For identifiers 0..15, data bits 12:10 give the source processor, and for other identifiers those bits are ignored. The slot for SGI id with source c is bit id*8+c; the slot for any other id n is bit 128+(n-16).
- R8: With `aff_route_i`=1 the identifier is data bits 23:0, and the source of both writes and activations is taken as 0.
- R9: Deactivation never changes `apr_o`. `eoi_valid_i` clears bit `eoi_prio_i`. `act_valid_i` sets bit `act_prio_i`, and the set wins when both name the same bit.
- R10: `act_valid_i` sets the active bit of its slot, and it wins over a deactivate of the same slot in the same cycle. The write's error outcome is judged on the state before that cycle.
- R11: `err_o` is high for exactly one cycle per refused write, never when `err_en_i`=0. Writes to any other offset are ignored without error.
- R12: Reset clears `active_map_o`, `apr_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | 32 | Write data |
| wr_secure_i | input | 1 | Write is a Secure access |
| sec_dis_i | input | 1 | Single security state selected |
| split_mode_i | input | 1 | Split mode when single security state |
| split_mode_s_i | input | 1 | Split mode for Secure writes |
| split_mode_ns_i | input | 1 | Split mode for Non-secure writes |
| aff_route_i | input | 1 | Affinity routing enabled |
| err_en_i | input | 1 | Enable error pulses for refused writes |
| act_valid_i | input | 1 | Activation strobe |
| act_id_i | input | 24 | Identifier to activate |
| act_src_i | input | 3 | Source processor of an activated SGI |
| act_prio_i | input | PRIO_IDX_W | Active-priority bit to set on activation |
| eoi_valid_i | input | 1 | Priority-drop strobe |
| eoi_prio_i | input | PRIO_IDX_W | Active-priority bit to clear |
| active_map_o | output | NUM_SLOTS | Active-state bitmap |
| apr_o | output | PRIO_BITS | Active-priority bitmap |
| err_o | output | 1 | Refused-write error pulse |

## Verification
Every result is registered, so the effect of a write, an activation or a priority drop appears at the first rising edge after it is presented. The error pulse appears at that same edge, and the bitmaps and the pulse are due together one cycle after the stimulus. The bench drives inputs on the falling edge and updates its model at that moment. It compares all three outputs at the next falling edge, half a period after the edge that updates them. Reset acts at once, so its check is taken a nanosecond after `rst_ni` falls.

// File: rtl/intr_deact_pkg.sv
package intr_deact_pkg;
  localparam int REG_W       = 32;
  localparam int ID_W        = 24;
  localparam int LEG_ID_W    = 10;
  localparam int SRC_LSB     = 10;
  localparam int SRC_FIELD_W = 3;
  localparam int RSV_FIRST   = 1020;
  localparam int RSV_LAST    = 1023;

  typedef enum logic [2:0] {
    V_IDLE,
    V_MODE_OFF,
    V_RESERVED,
    V_NOT_ACTIVE,
    V_APPLY
  } verdict_e;

  function automatic logic is_reserved(logic [ID_W-1:0] id);
    return (id >= ID_W'(RSV_FIRST)) && (id <= ID_W'(RSV_LAST));
  endfunction
endpackage

// File: rtl/intr_slot_map.sv
module intr_slot_map
  import intr_deact_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_SGI   = 16,
  parameter int NUM_SRC   = 8,
  parameter int NUM_SLOTS = NUM_SGI * NUM_SRC + NUM_IRQ - NUM_SGI,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [ID_W-1:0]        id_i,
  input  logic [SRC_FIELD_W-1:0] src_i,
  input  logic                   aff_i,
  output logic [SLOT_W-1:0]      slot_o,
  output logic                   valid_o,
  output logic                   rsv_o
);
  logic [31:0] id_w, src_w, slot_w;
  logic        is_sgi;
  logic        unused_hi;

  always_comb begin
    id_w   = {{(32-ID_W){1'b0}}, id_i};
    // affinity routing carries no source field
    src_w  = aff_i ? 32'd0 : {{(32-SRC_FIELD_W){1'b0}}, src_i};
    is_sgi = id_w < 32'(NUM_SGI);
    slot_w = is_sgi ? (id_w * 32'(NUM_SRC) + src_w)
                    : (id_w - 32'(NUM_SGI) + 32'(NUM_SGI * NUM_SRC));
    rsv_o  = is_reserved(id_i);
    valid_o = !rsv_o && (id_w < 32'(NUM_IRQ)) && (!is_sgi || src_w < 32'(NUM_SRC));
    slot_o = slot_w[SLOT_W-1:0];
  end

  assign unused_hi = ^slot_w[31:SLOT_W];
endmodule

// File: rtl/intr_deact_gate.sv
module intr_deact_gate
  import intr_deact_pkg::*;
(
  input  logic     fire_i,
  input  logic     secure_i,
  input  logic     sec_dis_i,
  input  logic     mode_i,
  input  logic     mode_s_i,
  input  logic     mode_ns_i,
  input  logic     hit_i,
  input  logic     rsv_i,
  input  logic     cur_act_i,
  output verdict_e verdict_o
);
  logic mode_on;

  always_comb begin
    mode_on = sec_dis_i ? mode_i : (secure_i ? mode_s_i : mode_ns_i);
    if (!fire_i)                 verdict_o = V_IDLE;
    else if (!mode_on)           verdict_o = V_MODE_OFF;
    else if (rsv_i)              verdict_o = V_RESERVED;
    else if (!hit_i || !cur_act_i) verdict_o = V_NOT_ACTIVE;
    else                         verdict_o = V_APPLY;
  end
endmodule

// File: rtl/intr_active_map.sv
module intr_active_map #(
  parameter int NUM_SLOTS = 176,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [SLOT_W-1:0]    set_slot_i,
  input  logic                 clr_i,
  input  logic [SLOT_W-1:0]    clr_slot_i,
  output logic [NUM_SLOTS-1:0] map_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic q, set_hit, clr_hit;
    assign set_hit = set_i && (set_slot_i == SLOT_W'(g));
    assign clr_hit = clr_i && (clr_slot_i == SLOT_W'(g));
    // activation wins over a same-cycle deactivate
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= 1'b0;
      else if (set_hit) q <= 1'b1;
      else if (clr_hit) q <= 1'b0;
    end
    assign map_o[g] = q;
  end
endmodule

// File: rtl/intr_prio_map.sv
module intr_prio_map #(
  parameter int PRIO_BITS  = 32,
  parameter int PRIO_IDX_W = $clog2(PRIO_BITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_i,
  input  logic [PRIO_IDX_W-1:0] set_idx_i,
  input  logic                  clr_i,
  input  logic [PRIO_IDX_W-1:0] clr_idx_i,
  output logic [PRIO_BITS-1:0]  map_o
);
  for (genvar g = 0; g < PRIO_BITS; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          q <= 1'b0;
      else if (set_i && set_idx_i == PRIO_IDX_W'(g))        q <= 1'b1;
      else if (clr_i && clr_idx_i == PRIO_IDX_W'(g))        q <= 1'b0;
    end
    assign map_o[g] = q;
  end
endmodule

// File: rtl/intr_deact_unit.sv
module intr_deact_unit
  import intr_deact_pkg::*;
#(
  parameter int NUM_IRQ   = 64,
  parameter int NUM_SGI   = 16,
  parameter int NUM_SRC   = 8,
  parameter int PRIO_BITS = 32,
  parameter int ADDR_W    = 16,
  parameter int DEACT_OFS = 'h1000,
  localparam int NUM_SLOTS  = NUM_SGI * NUM_SRC + NUM_IRQ - NUM_SGI,
  localparam int SLOT_W     = $clog2(NUM_SLOTS),
  localparam int PRIO_IDX_W = $clog2(PRIO_BITS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_valid_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [REG_W-1:0]       wr_data_i,
  input  logic                   wr_secure_i,
  input  logic                   sec_dis_i,
  input  logic                   split_mode_i,
  input  logic                   split_mode_s_i,
  input  logic                   split_mode_ns_i,
  input  logic                   aff_route_i,
  input  logic                   err_en_i,
  input  logic                   act_valid_i,
  input  logic [ID_W-1:0]        act_id_i,
  input  logic [SRC_FIELD_W-1:0] act_src_i,
  input  logic [PRIO_IDX_W-1:0]  act_prio_i,
  input  logic                   eoi_valid_i,
  input  logic [PRIO_IDX_W-1:0]  eoi_prio_i,
  output logic [NUM_SLOTS-1:0]   active_map_o,
  output logic [PRIO_BITS-1:0]   apr_o,
  output logic                   err_o
);
  logic                   wr_fire;
  logic [ID_W-1:0]        wr_id;
  logic [SRC_FIELD_W-1:0] wr_src;
  logic [SLOT_W-1:0]      wr_slot, act_slot;
  logic                   wr_hit, wr_rsv, act_hit, act_rsv;
  logic                   cur_act;
  verdict_e               verdict;
  logic                   clr, act_set, err_d, err_q;
  logic                   unused_top;

  assign wr_fire = wr_valid_i && (wr_addr_i == ADDR_W'(DEACT_OFS));
  assign wr_id   = aff_route_i ? wr_data_i[ID_W-1:0]
                               : {{(ID_W-LEG_ID_W){1'b0}}, wr_data_i[LEG_ID_W-1:0]};
  assign wr_src  = wr_data_i[SRC_LSB +: SRC_FIELD_W];
  assign unused_top = ^wr_data_i[REG_W-1:ID_W] ^ act_rsv;

  intr_slot_map #(
    .NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_SRC(NUM_SRC),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_wr_map (
    .id_i(wr_id), .src_i(wr_src), .aff_i(aff_route_i),
    .slot_o(wr_slot), .valid_o(wr_hit), .rsv_o(wr_rsv)
  );

  intr_slot_map #(
    .NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI), .NUM_SRC(NUM_SRC),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_act_map (
    .id_i(act_id_i), .src_i(act_src_i), .aff_i(aff_route_i),
    .slot_o(act_slot), .valid_o(act_hit), .rsv_o(act_rsv)
  );

  always_comb begin
    cur_act = 1'b0;
    if (wr_hit && (32'(wr_slot) < 32'(NUM_SLOTS))) cur_act = active_map_o[wr_slot];
  end

  intr_deact_gate u_gate (
    .fire_i(wr_fire), .secure_i(wr_secure_i), .sec_dis_i(sec_dis_i),
    .mode_i(split_mode_i), .mode_s_i(split_mode_s_i), .mode_ns_i(split_mode_ns_i),
    .hit_i(wr_hit), .rsv_i(wr_rsv), .cur_act_i(cur_act), .verdict_o(verdict)
  );

  assign clr     = (verdict == V_APPLY);
  assign act_set = act_valid_i && act_hit;
  assign err_d   = err_en_i && ((verdict == V_MODE_OFF) || (verdict == V_NOT_ACTIVE));

  intr_active_map #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_active (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(act_set), .set_slot_i(act_slot),
    .clr_i(clr), .clr_slot_i(wr_slot),
    .map_o(active_map_o)
  );

  intr_prio_map #(.PRIO_BITS(PRIO_BITS), .PRIO_IDX_W(PRIO_IDX_W)) u_prio (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(act_valid_i), .set_idx_i(act_prio_i),
    .clr_i(eoi_valid_i), .clr_idx_i(eoi_prio_i),
    .map_o(apr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end
  assign err_o = err_q;
endmodule

// File: rtl/intr_deact_chk.sv
module intr_deact_chk #(
  parameter int NUM_SLOTS = 176,
  parameter int PRIO_BITS = 32,
  parameter int ADDR_W    = 16,
  parameter int DEACT_OFS = 'h1000
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_valid_i,
  input logic [ADDR_W-1:0]    wr_addr_i,
  input logic                 wr_secure_i,
  input logic                 sec_dis_i,
  input logic                 split_mode_i,
  input logic                 split_mode_s_i,
  input logic                 act_valid_i,
  input logic                 eoi_valid_i,
  input logic                 err_en_i,
  input logic [NUM_SLOTS-1:0] active_map_o,
  input logic [PRIO_BITS-1:0] apr_o,
  input logic                 err_o
);
  logic fire;
  assign fire = wr_valid_i && (wr_addr_i == ADDR_W'(DEACT_OFS));

  a_r1_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_valid_i |=> ($countones(active_map_o) <= $countones($past(active_map_o))));

  a_r4_mode_off_keeps_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sec_dis_i && !split_mode_i && !act_valid_i) |=> $stable(active_map_o));

  a_r3_secure_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !sec_dis_i && wr_secure_i && !split_mode_s_i && !act_valid_i)
      |=> $stable(active_map_o));

  a_r9_deact_keeps_apr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eoi_valid_i && !act_valid_i) |=> $stable(apr_o));

  a_r11_err_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire || !err_en_i) |=> !err_o);
endmodule

bind intr_deact_unit intr_deact_chk #(
  .NUM_SLOTS(NUM_SLOTS), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .DEACT_OFS(DEACT_OFS)
) u_chk (.*);

// File: tb/intr_deact_unit_test.sv
`timescale 1ns/1ps
module intr_deact_unit_test;
  localparam int NUM_IRQ = 64, NUM_SGI = 16, NUM_SRC = 8, PRIO_BITS = 32;
  localparam int NSL = NUM_SGI * NUM_SRC + NUM_IRQ - NUM_SGI;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 0, wr_secure_i = 0, sec_dis_i = 0, split_mode_i = 0;
  logic split_mode_s_i = 0, split_mode_ns_i = 0, aff_route_i = 0, err_en_i = 0;
  logic act_valid_i = 0, eoi_valid_i = 0;
  logic [15:0] wr_addr_i = 16'h1000;
  logic [31:0] wr_data_i = 0;
  logic [23:0] act_id_i = 0;
  logic [2:0]  act_src_i = 0;
  logic [4:0]  act_prio_i = 0, eoi_prio_i = 0;
  logic [NSL-1:0]       active_map_o;
  logic [PRIO_BITS-1:0] apr_o;
  logic                 err_o;

  bit [NSL-1:0]       m_act;
  bit [PRIO_BITS-1:0] m_apr;
  bit                 m_err;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  intr_deact_unit uut (.*);

  function automatic int ref_slot(int id, int src, bit aff);
    int s = aff ? 0 : src;
    if (id >= 1020 && id <= 1023) return -1;
    if (id >= NUM_IRQ) return -1;
    if (id < NUM_SGI) return id * NUM_SRC + s;
    return NUM_SGI * NUM_SRC + id - NUM_SGI;
  endfunction

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit [NSL-1:0] pre = m_act;
    m_err = 0;
    if (wr_valid_i && wr_addr_i == 16'h1000) begin
      bit on = sec_dis_i ? split_mode_i : (wr_secure_i ? split_mode_s_i : split_mode_ns_i);
      int id = aff_route_i ? int'(wr_data_i[23:0]) : int'(wr_data_i[9:0]);
      int s  = ref_slot(id, int'(wr_data_i[12:10]), aff_route_i);
      if (!on) m_err = err_en_i;
      else if (id >= 1020 && id <= 1023) m_err = 0;
      else if (s < 0 || !pre[s]) m_err = err_en_i;
      else m_act[s] = 0;
    end
    if (eoi_valid_i) m_apr[eoi_prio_i] = 0;
    if (act_valid_i) begin
      int s = ref_slot(int'(act_id_i), int'(act_src_i), aff_route_i);
      if (s >= 0) m_act[s] = 1;
      m_apr[act_prio_i] = 1;
    end
  endtask

  task automatic cycle(string tag);
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " map"}, 256'(active_map_o), 256'(m_act));
    chk({tag, " apr"}, 256'(apr_o), 256'(m_apr));
    chk({tag, " err"}, 256'(err_o), 256'(m_err));
    wr_valid_i = 0; act_valid_i = 0; eoi_valid_i = 0; wr_addr_i = 16'h1000;
  endtask

  task automatic wr(logic [31:0] d, logic sec, string tag);
    wr_valid_i = 1; wr_data_i = d; wr_secure_i = sec;
    cycle(tag);
  endtask

  task automatic act(int id, int src, int prio, string tag);
    act_valid_i = 1; act_id_i = 24'(id); act_src_i = 3'(src); act_prio_i = 5'(prio);
    cycle(tag);
  endtask

  function automatic int rand_id();
    int r = int'($urandom % 20);
    if (r == 0) return 1020 + int'($urandom % 4);
    if (r == 1) return 64 + int'($urandom % 100);
    if (r < 8) return int'($urandom % 16);
    return int'($urandom % 64);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk("R12 reset map", 256'(active_map_o), 256'd0);
    chk("R12 reset err", 256'(err_o), 256'd0);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 / R9: activate id 40 prio 5, deactivate with single security state
    sec_dis_i = 1; split_mode_i = 1; err_en_i = 1;
    act(40, 0, 5, "R9 activate sets apr");
    chk("R10 slot 152 set", 256'(active_map_o[152]), 256'd1);
    wr(32'd40, 0, "R1 deactivate");
    chk("R1 slot 152 clear", 256'(active_map_o[152]), 256'd0);
    chk("R9 apr kept", 256'(apr_o[5]), 256'd1);
    eoi_valid_i = 1; eoi_prio_i = 5; cycle("R9 eoi clears");
    chk("R9 apr bit 5 clear", 256'(apr_o[5]), 256'd0);

    // R2: single-state mode off, secure attribute irrelevant
    act(41, 0, 1, "R2 setup");
    split_mode_i = 0; split_mode_s_i = 1; split_mode_ns_i = 1;
    wr(32'd41, 1, "R2/R4 mode off ignored");
    chk("R4 err pulse", 256'(err_o), 256'd1);
    cycle("R11 pulse one cycle");
    chk("R11 err dropped", 256'(err_o), 256'd0);

    // R3: two security states
    sec_dis_i = 0; split_mode_s_i = 0; split_mode_ns_i = 1;
    wr(32'd41, 1, "R3 secure gated off");
    chk("R3 slot kept", 256'(active_map_o[153]), 256'd1);
    wr(32'd41, 0, "R3 nonsecure applies");
    chk("R3 slot cleared", 256'(active_map_o[153]), 256'd0);

    // R5 / R11 / R6
    wr(32'd42, 0, "R5 not active");
    wr(32'd100, 0, "R5 out of range");
    err_en_i = 0;
    wr(32'd42, 0, "R11 err disabled");
    err_en_i = 1;
    wr(32'd1021, 0, "R6 reserved id");
    act(43, 0, 2, "R11 setup");
    wr_addr_i = 16'h1004; wr_valid_i = 1; wr_data_i = 32'd43; cycle("R11 other offset");

    // R7 legacy decode with per-source SGI slots
    act(3, 5, 0, "R7 sgi src5");
    act(3, 2, 0, "R7 sgi src2");
    wr(32'hABCD_E000 | (32'd5 << 10) | 32'd3, 0, "R7 junk high bits");
    chk("R7 slot 29 clear", 256'(active_map_o[29]), 256'd0);
    chk("R7 slot 26 kept", 256'(active_map_o[26]), 256'd1);
    act(20, 0, 0, "R7 setup spi");
    wr((32'd7 << 10) | 32'd20, 0, "R7 spi ignores src bits");
    chk("R7 slot 132 clear", 256'(active_map_o[132]), 256'd0);

    // R8 affinity routing
    aff_route_i = 1;
    act(2, 6, 0, "R8 sgi src forced 0");
    chk("R8 slot 16 set", 256'(active_map_o[16]), 256'd1);
    wr(32'h0000_0402, 0, "R8 wide id out of range");
    wr(32'hFF00_0002, 0, "R8 deactivate");
    chk("R8 slot 16 clear", 256'(active_map_o[16]), 256'd0);
    aff_route_i = 0;

    // R10 same-cycle activate and deactivate
    act(50, 0, 0, "R10 setup");
    act_valid_i = 1; act_id_i = 50; act_src_i = 0; wr_valid_i = 1; wr_data_i = 32'd50;
    cycle("R10 active slot collision");
    act_valid_i = 1; act_id_i = 51; wr_valid_i = 1; wr_data_i = 32'd51;
    cycle("R10 inactive slot collision");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 50 == 0) begin
        sec_dis_i = 1'($urandom); split_mode_i = ($urandom % 4) != 0;
        split_mode_s_i = ($urandom % 4) != 0; split_mode_ns_i = ($urandom % 4) != 0;
        aff_route_i = ($urandom % 4) == 0; err_en_i = ($urandom % 4) != 0;
      end
      act_valid_i = ($urandom % 3) == 0;
      act_id_i = 24'(rand_id()); act_src_i = 3'($urandom); act_prio_i = 5'($urandom);
      eoi_valid_i = ($urandom % 5) == 0; eoi_prio_i = 5'($urandom);
      wr_valid_i = 1'($urandom); wr_secure_i = 1'($urandom);
      wr_addr_i = ($urandom % 10 == 0) ? 16'($urandom) : 16'h1000;
      begin
        logic [31:0] d = $urandom;
        int id = rand_id();
        if (aff_route_i) begin
          if ($urandom % 8 != 0) d[23:0] = 24'(id);
        end else d[9:0] = 10'(id);
        wr_data_i = d;
      end
      cycle("R1/R5/R7/R10 random");
    end

    // R12 asynchronous reset mid-run
    rst_ni = 0;
    #1;
    chk("R12 async map", 256'(active_map_o), 256'd0);
    chk("R12 async apr", 256'(apr_o), 256'd0);
    chk("R12 async err", 256'(err_o), 256'd0);
    m_act = '0; m_apr = '0;
    @(negedge clk_i);
    rst_ni = 1;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule